// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm and Periodic Tick

This block is a system timer that advances on strobes from a 32768 Hz slow clock. The strobes arrive as one-cycle pulses in the system clock domain. A prescaler divides those strobes into increments of a free-running real-time counter. The counter is 20 bits wide by default and wraps modulo 2^CNT_W. An alarm register holds an absolute counter value; its flag rises when the counter steps onto that value. A periodic interval unit counts slow strobes down from a programmed period and reloads itself each time it expires.

Four sources feed a status register: the periodic tick, a watchdog overflow input, the counter increment and the alarm. Reading the status register returns the flags and clears them. A mask register is changed through separate write-one-to-set and write-one-to-clear addresses. The interrupt line is the OR of the pending flags that are enabled.

The periodic unit is a two-state machine. It sits in `PIT_IDLE` while the period is zero and in `PIT_COUNT` while a nonzero period is armed. Its transitions are:
- **arm**: `PIT_IDLE` to `PIT_COUNT`, on a nonzero period write.
- **disarm**: any state to `PIT_IDLE`, on a zero period write.
- **restart**: `PIT_COUNT` to `PIT_COUNT`, on a nonzero period write, which reloads the down-counter.
- **reload**: `PIT_COUNT` to `PIT_COUNT`, on expiry, which raises the flag and reloads the down-counter.

Top module: `slowclk_sys_timer`

## Requirements
- R1: After reset the counter, status, mask, period and alarm read 0, the interrupt is low and the prescale register reads PRE_DEF (32768 by default, one increment per second).
- R2: The counter advances by one after every N slow strobes, where N is the prescale value. A prescale write restarts the division, and N=1 advances the counter on every strobe.
- R3: The counter wraps from 2^CNT_W-1 to 0.
- R4: The alarm flag (status bit 3) sets on the increment that makes the counter equal to the alarm register.
- R5: Writing the alarm register with the counter's present value raises no flag until the counter has wrapped fully around to that value again.
- R6: With a nonzero period P, the periodic flag (status bit 0) sets after every P slow strobes and the count reloads by itself. Writing the period restarts the count.
- R7: A period of 0 never sets the periodic flag.
- R8: The increment flag (status bit 2) sets on every counter increment. A one-cycle pulse on wdog_ovf_i sets the watchdog flag (status bit 1).
- R9: Reading status returns the flags and clears them. A flag event in the same cycle as the read is kept pending for the next read.
- R10: Writing ones to address 5 sets those mask bits and writing ones to address 6 clears them. Other bits are unchanged, and the mask reads at address 7 with the same bit positions as status.
- R11: irq_o is high exactly while some pending flag is enabled in the mask, and it stays high until the status register is read.
- R12: Read data appears on bus_rdata_o in the cycle after bus_rd_i. The map is 0 prescale, 1 period, 2 alarm, 3 counter, 4 status; write-only addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick_i | input | 1 | One-cycle strobe per slow-clock period |
| wdog_ovf_i | input | 1 | Watchdog overflow event pulse |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the alarm written with the live counter value. The flag must stay silent for a complete counter revolution and then fire exactly on return. The bench builds the counter narrow (12 bits) and sets the prescale to 1, so one revolution takes 4096 strobes. It then reads status one strobe before and one strobe after the return. It also lines a watchdog pulse up in the same cycle as a status read, to show that the event survives the clear.

// File: rtl/slowtmr_pkg.sv
package slowtmr_pkg;
    localparam int NFLAG  = 4;
    localparam int FL_PER = 0;
    localparam int FL_WDG = 1;
    localparam int FL_INC = 2;
    localparam int FL_ALM = 3;

    typedef enum logic [2:0] {
        RA_PRESCALE = 3'd0,
        RA_PERIOD   = 3'd1,
        RA_ALARM    = 3'd2,
        RA_COUNT    = 3'd3,
        RA_STATUS   = 3'd4,
        RA_MSET     = 3'd5,
        RA_MCLR     = 3'd6,
        RA_MASK     = 3'd7
    } reg_addr_e;

    typedef enum logic {
        PIT_IDLE  = 1'b0,
        PIT_COUNT = 1'b1
    } pit_state_e;
endpackage

// File: rtl/slowtmr_rtc.sv
module slowtmr_rtc #(
    parameter int CNT_W = 20,
    parameter int PRE_W = 16,
    parameter logic [PRE_W-1:0] PRE_DEF = 16'd32768
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_tick,
    input  logic             pre_we,
    input  logic [PRE_W-1:0] pre_wdata,
    input  logic             alm_we,
    input  logic [CNT_W-1:0] alm_wdata,
    output logic [PRE_W-1:0] pre_q,
    output logic [CNT_W-1:0] alm_q,
    output logic [CNT_W-1:0] count_q,
    output logic             inc_evt,
    output logic             alm_evt
);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [PRE_W-1:0] div_q;
    logic [CNT_W-1:0] count_nxt;

    assign count_nxt = count_q + CNT_ONE;
    assign inc_evt   = slow_tick && !pre_we && (div_q == pre_q - PRE_ONE);
    assign alm_evt   = inc_evt && (count_nxt == alm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= PRE_DEF;
            div_q   <= '0;
            alm_q   <= '0;
            count_q <= '0;
        end else begin
            if (pre_we) begin
                pre_q <= pre_wdata;
                div_q <= '0;
            end else if (slow_tick) begin
                div_q <= inc_evt ? '0 : div_q + PRE_ONE;
            end
            if (inc_evt) count_q <= count_nxt;
            if (alm_we)  alm_q   <= alm_wdata;
        end
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (count_q != $past(count_q)) |-> (count_q == $past(count_q) + CNT_ONE));

    assert_alarm_R4: assert property (@(posedge clk) disable iff (rst)
        alm_evt |=> (count_q == $past(alm_q)));
endmodule

// File: rtl/slowtmr_pit.sv
module slowtmr_pit
    import slowtmr_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_tick,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    output logic [PER_W-1:0] period_q,
    output logic             pit_evt
);
    localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);

    pit_state_e       state_q, state_n;
    logic [PER_W-1:0] cnt_q, cnt_n, per_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PIT_IDLE;
            cnt_q    <= '0;
            period_q <= '0;
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            period_q <= per_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        per_n   = period_q;
        if (load) begin
            per_n   = load_val;
            cnt_n   = load_val;
            state_n = (load_val == '0) ? PIT_IDLE : PIT_COUNT;
        end else begin
            unique case (state_q)
                PIT_IDLE: ;
                PIT_COUNT: begin
                    if (slow_tick)
                        cnt_n = (cnt_q == PER_ONE) ? period_q : cnt_q - PER_ONE;
                end
                default: state_n = PIT_IDLE;
            endcase
        end
    end

    always_comb begin
        pit_evt = (state_q == PIT_COUNT) && slow_tick && !load && (cnt_q == PER_ONE);
    end

    assert_off_R7: assert property (@(posedge clk) disable iff (rst)
        ((period_q == '0) && !load) |=> !pit_evt);

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (pit_evt && !load) |=> (cnt_q == period_q));
endmodule

// File: rtl/slowtmr_flags.sv
module slowtmr_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] events,
    input  logic          rd_clear,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [NF-1:0] wbits,
    output logic [NF-1:0] status_q,
    output logic [NF-1:0] mask_q,
    output logic          irq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (rd_clear ? '0 : status_q) | events;
            if (clr_we)      mask_q <= mask_q & ~wbits;
            else if (set_we) mask_q <= mask_q | wbits;
        end
    end

    assign irq_o = |(status_q & mask_q);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && (events == '0)) |=> (status_q == '0));

    assert_mset_R10: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_we) |=> ((mask_q & $past(wbits)) == $past(wbits)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !rd_clear && !clr_we) |=> irq_o);
endmodule

// File: rtl/slowclk_sys_timer.sv
module slowclk_sys_timer
    import slowtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int PRE_W  = 16,
    parameter logic [PRE_W-1:0] PRE_DEF = 16'd32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick_i,
    input  logic              wdog_ovf_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    reg_addr_e        addr;
    logic [PRE_W-1:0] pre_q, period_q;
    logic [CNT_W-1:0] alm_q, count_q;
    logic [NFLAG-1:0] status_q, mask_q, events;
    logic             inc_evt, alm_evt, pit_evt;
    logic             unused_wdata;

    assign addr         = reg_addr_e'(bus_addr_i);
    assign unused_wdata = ^bus_wdata_i;

    slowtmr_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_DEF(PRE_DEF)) rtc_i (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick_i),
        .pre_we    (bus_wr_i && addr == RA_PRESCALE),
        .pre_wdata (bus_wdata_i[PRE_W-1:0]),
        .alm_we    (bus_wr_i && addr == RA_ALARM),
        .alm_wdata (bus_wdata_i[CNT_W-1:0]),
        .pre_q     (pre_q),
        .alm_q     (alm_q),
        .count_q   (count_q),
        .inc_evt   (inc_evt),
        .alm_evt   (alm_evt)
    );

    slowtmr_pit #(.PER_W(PRE_W)) pit_i (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick_i),
        .load      (bus_wr_i && addr == RA_PERIOD),
        .load_val  (bus_wdata_i[PRE_W-1:0]),
        .period_q  (period_q),
        .pit_evt   (pit_evt)
    );

    always_comb begin
        events         = '0;
        events[FL_PER] = pit_evt;
        events[FL_WDG] = wdog_ovf_i;
        events[FL_INC] = inc_evt;
        events[FL_ALM] = alm_evt;
    end

    slowtmr_flags #(.NF(NFLAG)) flags_i (
        .clk      (clk),
        .rst      (rst),
        .events   (events),
        .rd_clear (bus_rd_i && addr == RA_STATUS),
        .set_we   (bus_wr_i && addr == RA_MSET),
        .clr_we   (bus_wr_i && addr == RA_MCLR),
        .wbits    (bus_wdata_i[NFLAG-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq_o    (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata_o <= '0;
        end else if (bus_rd_i) begin
            unique case (addr)
                RA_PRESCALE: bus_rdata_o <= DATA_W'(pre_q);
                RA_PERIOD:   bus_rdata_o <= DATA_W'(period_q);
                RA_ALARM:    bus_rdata_o <= DATA_W'(alm_q);
                RA_COUNT:    bus_rdata_o <= DATA_W'(count_q);
                RA_STATUS:   bus_rdata_o <= DATA_W'(status_q);
                RA_MASK:     bus_rdata_o <= DATA_W'(mask_q);
                default:     bus_rdata_o <= '0;
            endcase
        end
    end

    assert_rdlat_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/slowclk_sys_timer_tb_top.sv
module slowclk_sys_timer_tb_top;
    localparam int CW = 12;
    localparam logic [31:0] CMASK = (32'd1 << CW) - 32'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick_i = 1'b0;
    logic        wdog_ovf_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [2:0]  bus_addr_i = 3'd0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    slowclk_sys_timer #(.DATA_W(32), .CNT_W(CW), .PRE_W(16), .PRE_DEF(16'd32768)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .slow_tick_i (slow_tick_i),
        .wdog_ovf_i  (wdog_ovf_i),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    // prescale, strobes, expected counter advance
    localparam logic [47:0] VEC [0:5] = '{
        {16'd1, 16'd5, 16'd5},
        {16'd2, 16'd6, 16'd3},
        {16'd3, 16'd7, 16'd2},
        {16'd4, 16'd3, 16'd0},
        {16'd5, 16'd5, 16'd1},
        {16'd2, 16'd1, 16'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_tick_i = 1'b1;
            @(negedge clk) slow_tick_i = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        v = bus_rdata_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0, c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(3'd3, v); check("R1 count", v, 32'd0);
        rd(3'd4, v); check("R1 status", v, 32'd0);
        rd(3'd7, v); check("R1 mask", v, 32'd0);
        rd(3'd1, v); check("R1 period", v, 32'd0);
        rd(3'd2, v); check("R1 alarm", v, 32'd0);
        rd(3'd0, v); check("R1 prescale", v, 32'd32768);

        // R2 prescale table
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, {16'd0, VEC[i][47:32]});
            rd(3'd3, c0);
            slow(int'(VEC[i][31:16]));
            rd(3'd3, c1);
            check("R2 advance", (c1 - c0) & CMASK, {16'd0, VEC[i][15:0]});
        end
        rd(3'd5, v); check("R12 write-only reads 0", v, 32'd0);

        // R3 wrap
        wr(3'd0, 32'd1);
        rd(3'd3, c0);
        slow(int'(CMASK - c0));
        rd(3'd3, v); check("R3 top", v, CMASK);
        slow(1);
        rd(3'd3, v); check("R3 wrap", v, 32'd0);

        // R4 alarm on future value
        rd(3'd3, c0);
        wr(3'd2, (c0 + 32'd3) & CMASK);
        rd(3'd2, v); check("R12 alarm readback", v, (c0 + 32'd3) & CMASK);
        rd(3'd4, v);
        slow(2);
        rd(3'd4, v); check("R4 early", v & 32'h8, 32'h0);
        slow(1);
        rd(3'd4, v); check("R4 hit", v & 32'h8, 32'h8);

        // R5 alarm equal to current count
        rd(3'd3, c0);
        wr(3'd2, c0);
        rd(3'd4, v);
        slow(1);
        rd(3'd4, v); check("R5 no immediate", v & 32'h8, 32'h0);
        slow(int'(CMASK) - 1);
        rd(3'd4, v); check("R5 one before", v & 32'h8, 32'h0);
        slow(1);
        rd(3'd4, v); check("R5 after wrap", v & 32'h8, 32'h8);

        // R6 periodic
        wr(3'd1, 32'd4);
        rd(3'd4, v);
        slow(3);
        rd(3'd4, v); check("R6 before", v & 32'h1, 32'h0);
        slow(1);
        rd(3'd4, v); check("R6 expire", v & 32'h1, 32'h1);
        slow(3);
        rd(3'd4, v); check("R6 reload early", v & 32'h1, 32'h0);
        slow(1);
        rd(3'd4, v); check("R6 reload", v & 32'h1, 32'h1);
        slow(2);
        wr(3'd1, 32'd4);
        rd(3'd4, v);
        slow(3);
        rd(3'd4, v); check("R6 restart early", v & 32'h1, 32'h0);
        slow(1);
        rd(3'd4, v); check("R6 restart", v & 32'h1, 32'h1);

        // R7 period zero
        wr(3'd1, 32'd0);
        rd(3'd4, v);
        slow(10);
        rd(3'd4, v); check("R7 disabled", v & 32'h1, 32'h0);

        // R8 increment and watchdog flags
        rd(3'd4, v);
        slow(1);
        rd(3'd4, v); check("R8 inc set", v & 32'h4, 32'h4);
        wr(3'd0, 32'd3);
        rd(3'd4, v);
        slow(2);
        rd(3'd4, v); check("R8 no inc", v & 32'h4, 32'h0);
        @(negedge clk) wdog_ovf_i = 1'b1;
        @(negedge clk) wdog_ovf_i = 1'b0;
        rd(3'd4, v); check("R8 wdog", v, 32'h2);
        rd(3'd4, v); check("R9 cleared", v, 32'h0);

        // R9 event during status read
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = 3'd4; wdog_ovf_i = 1'b1;
        @(negedge clk);
        bus_rd_i = 1'b0; wdog_ovf_i = 1'b0;
        check("R9 old value", bus_rdata_o, 32'h0);
        rd(3'd4, v); check("R9 kept", v, 32'h2);

        // R10 mask set/clear
        wr(3'd5, 32'h5);
        rd(3'd7, v); check("R10 set", v, 32'h5);
        wr(3'd6, 32'h1);
        rd(3'd7, v); check("R10 clear", v, 32'h4);
        wr(3'd5, 32'h8);
        rd(3'd7, v); check("R10 set more", v, 32'hC);

        // R11 interrupt
        wr(3'd6, 32'hF);
        wr(3'd5, 32'h2);
        wr(3'd0, 32'd1);
        rd(3'd4, v);
        slow(1);
        check("R11 masked", {31'd0, irq_o}, 32'd0);
        @(negedge clk) wdog_ovf_i = 1'b1;
        @(negedge clk) wdog_ovf_i = 1'b0;
        check("R11 raised", {31'd0, irq_o}, 32'd1);
        slow(2);
        check("R11 held", {31'd0, irq_o}, 32'd1);
        rd(3'd4, v);
        check("R11 cleared", {31'd0, irq_o}, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule